// File: doc/BRIEF.md
# Debug Port Link and Wake Controller

This block sits beside the two-wire serial debug pins and decides whether a debug session is live. The pin clock and data are brought into the system clock domain, and a small recogniser watches the data bits taken on each rising pin-clock edge. A probe opens a session with a fixed handshake: a long run of ones, a 16-bit select word, another long run of ones and a short idle of zeros. The probe ends the session with a run of ones followed by a 16-bit dormant word. While a session is live the block raises a status flag that boot firmware polls. It also allows the target to drive the data pad, except during turnaround slots.

Out of power-on reset the pins are in debug mode, with a pull-up requested on the data line and a pull-down requested on the clock line. If the chip is in shutdown, only a fully matched handshake produces a wake request. Firmware can lock the port off, which hands the pins back to general-purpose use. Only a power-on reset clears the lock. If the external reset pin is held asserted while power-on reset releases, the lock input is ignored until the next power-on reset, so a probe can always reach a device whose firmware would otherwise lock it.

Top module: `dbg_link_wake`

## Requirements
- R1: After power-on reset (`por_n` low, then high), `pad_dbg_mode`, `pull_up_req` and `pull_dn_req` are 1, and `link_up`, `wake_req` and `swdio_oe` are 0.
- R2: `link_up` goes to 1 after the following bits, each taken on a rising `swclk_pin` edge: at least 50 ones, then the select word 0xE79E least significant bit first, then at least 50 ones, then 2 zeros. After only one trailing zero, `link_up` is still 0.
- R3: `swdio_oe` is 1 only when `link_up` is 1, `dp_drive_req` is 1 and `dp_turnaround` is 0. Otherwise it is 0.
- R4: If `shutdown` is 1 when a handshake as in R2 completes, `wake_req` goes to 1. It stays 1 until `shutdown` returns to 0, and then it drops in the same cycle.
- R5: A handshake with a wrong select word, or with a first run of only 49 ones, leaves `link_up` and `wake_req` at 0.
- R6: While linked, a run of at least 50 ones followed by the dormant word 0xE3BC least significant bit first clears `link_up`. A run of ones followed by any other word leaves `link_up` at 1.
- R7: A `fw_disable_pulse` locks the port. From the next cycle, `pad_dbg_mode`, `pull_up_req`, `pull_dn_req`, `link_up`, `wake_req` and `swdio_oe` are 0, and a valid handshake no longer links. Only a power-on reset unlocks the port.
- R8: If `rst_pin_held` is 1 when `por_n` releases, `fw_disable_pulse` has no effect until the next power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_pin_held | input | 1 | External reset pin asserted (active high), sampled as power-on reset releases |
| swclk_pin | input | 1 | Debug serial clock from the pad |
| swdio_in | input | 1 | Debug serial data from the pad |
| dp_drive_req | input | 1 | Debug-port engine wants to drive the data pad |
| dp_turnaround | input | 1 | Current slot is a line-ownership turnaround |
| shutdown | input | 1 | Chip is in shutdown mode |
| fw_disable_pulse | input | 1 | Single-cycle firmware request to lock the port off |
| swdio_oe | output | 1 | Output enable for the data pad |
| link_up | output | 1 | Session status flag polled by firmware |
| wake_req | output | 1 | Request to leave shutdown |
| pad_dbg_mode | output | 1 | Pins are in debug mode (0 means general-purpose) |
| pull_up_req | output | 1 | Pull-up request for the data pad |
| pull_dn_req | output | 1 | Pull-down request for the clock pad |

## Verification
On every cycle the assertions check the following: the lock never releases without a power-on reset, the pad output enable stays low in every turnaround slot, a locked port keeps its flag, wake and enable outputs quiet, and a wake request appears only during shutdown and alongside a live link. Only the bench's directed bit streams can show that the exact handshake and dormant words are recognised. The same applies to the boundaries: a 49-versus-50 ones run, one versus two idle zeros, a one-bit word error, and the external-reset hold captured at power-on.

// File: rtl/dlw_pkg.sv
package dlw_pkg;
   typedef enum logic [2:0] {
      ST_HUNT,
      ST_SEL,
      ST_RST2,
      ST_IDLE,
      ST_UP_HUNT,
      ST_UP_SEL
   } dlw_state_e;

   localparam logic [15:0] DLW_SEL_WORD  = 16'hE79E;
   localparam logic [15:0] DLW_DORM_WORD = 16'hE3BC;
endpackage

// File: rtl/dlw_edge_sync.sv
module dlw_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic sck_i,
   input  logic dio_i,
   output logic samp_o,
   output logic bit_o
);
   logic [1:0] pipe [STAGES];
   logic       sck_prev_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) pipe[0] <= 2'b00;
      else        pipe[0] <= {sck_i, dio_i};
   end

   for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n) pipe[g] <= 2'b00;
         else        pipe[g] <= pipe[g-1];
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) sck_prev_q <= 1'b0;
      else        sck_prev_q <= pipe[STAGES-1][1];
   end

   assign samp_o = pipe[STAGES-1][1] & ~sck_prev_q;
   assign bit_o  = pipe[STAGES-1][0];
endmodule

// File: rtl/dlw_seq_detect.sv
module dlw_seq_detect
   import dlw_pkg::*;
#(
   parameter int              LR_LEN    = 50,
   parameter int              IDLE_LEN  = 2,
   parameter int              PAT_W     = 16,
   parameter logic [PAT_W-1:0] SEL_PAT  = PAT_W'(DLW_SEL_WORD),
   parameter logic [PAT_W-1:0] DORM_PAT = PAT_W'(DLW_DORM_WORD)
) (
   input  logic clk,
   input  logic por_n,
   input  logic enable,
   input  logic samp,
   input  logic bit_i,
   output logic connected,
   output logic conn_evt
);
   localparam int CW = $clog2(LR_LEN + 1);
   localparam int IW = $clog2(IDLE_LEN + 1);
   localparam int BW = $clog2(PAT_W + 1);
   localparam logic [CW-1:0] ONES_MAX  = CW'(LR_LEN);
   localparam logic [IW-1:0] ZERO_LAST = IW'(IDLE_LEN - 1);
   localparam logic [BW-1:0] BIT_LAST  = BW'(PAT_W - 1);

   dlw_state_e       state_q;
   logic [CW-1:0]    ones_q;
   logic [IW-1:0]    zer_q;
   logic [BW-1:0]    bits_q;
   logic [PAT_W-1:0] sr_q;
   logic [PAT_W-1:0] sr_nxt;
   logic [PAT_W-1:0] want;
   logic             ones_full;

   assign sr_nxt    = {bit_i, sr_q[PAT_W-1:1]};
   assign want      = (state_q == ST_SEL) ? SEL_PAT : DORM_PAT;
   assign ones_full = (ones_q == ONES_MAX);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         state_q  <= ST_HUNT;
         ones_q   <= '0;
         zer_q    <= '0;
         bits_q   <= '0;
         sr_q     <= '0;
         conn_evt <= 1'b0;
      end else if (!enable) begin
         state_q  <= ST_HUNT;
         ones_q   <= '0;
         zer_q    <= '0;
         bits_q   <= '0;
         conn_evt <= 1'b0;
      end else begin
         conn_evt <= 1'b0;
         if (samp) begin
            case (state_q)
               ST_HUNT, ST_UP_HUNT, ST_RST2: begin
                  if (bit_i) begin
                     if (!ones_full) ones_q <= ones_q + 1'b1;
                  end else if (!ones_full) begin
                     ones_q  <= '0;
                     state_q <= (state_q == ST_UP_HUNT) ? ST_UP_HUNT : ST_HUNT;
                  end else if (state_q == ST_RST2) begin
                     state_q <= ST_IDLE;
                     zer_q   <= IW'(1);
                  end else begin
                     sr_q    <= sr_nxt;
                     bits_q  <= BW'(1);
                     state_q <= (state_q == ST_HUNT) ? ST_SEL : ST_UP_SEL;
                  end
               end
               ST_SEL, ST_UP_SEL: begin
                  sr_q   <= sr_nxt;
                  bits_q <= bits_q + 1'b1;
                  if (bits_q == BIT_LAST) begin
                     bits_q <= '0;
                     ones_q <= '0;
                     if (sr_nxt == want)
                        state_q <= (state_q == ST_SEL) ? ST_RST2 : ST_HUNT;
                     else
                        state_q <= (state_q == ST_SEL) ? ST_HUNT : ST_UP_HUNT;
                  end
               end
               ST_IDLE: begin
                  if (bit_i) begin
                     state_q <= ST_HUNT;
                     ones_q  <= '0;
                  end else if (zer_q == ZERO_LAST) begin
                     state_q  <= ST_UP_HUNT;
                     ones_q   <= '0;
                     conn_evt <= 1'b1;
                  end else begin
                     zer_q <= zer_q + 1'b1;
                  end
               end
               default: state_q <= ST_HUNT;
            endcase
         end
      end
   end

   assign connected = (state_q == ST_UP_HUNT) || (state_q == ST_UP_SEL);
endmodule

// File: rtl/dlw_lock.sv
module dlw_lock (
   input  logic clk,
   input  logic por_n,
   input  logic rst_pin_held,
   input  logic fw_disable_pulse,
   output logic locked
);
   logic boot_seen_q;
   logic blocked_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         boot_seen_q <= 1'b0;
         blocked_q   <= 1'b0;
         locked      <= 1'b0;
      end else begin
         if (!boot_seen_q) begin
            boot_seen_q <= 1'b1;
            blocked_q   <= rst_pin_held;
         end
         if (fw_disable_pulse && boot_seen_q && !blocked_q)
            locked <= 1'b1;
      end
   end
endmodule

// File: rtl/dbg_link_wake.sv
module dbg_link_wake
   import dlw_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int LR_LEN      = 50,
   parameter int IDLE_LEN    = 2,
   parameter int PAT_W       = 16
) (
   input  logic clk,
   input  logic por_n,
   input  logic rst_pin_held,
   input  logic swclk_pin,
   input  logic swdio_in,
   input  logic dp_drive_req,
   input  logic dp_turnaround,
   input  logic shutdown,
   input  logic fw_disable_pulse,
   output logic swdio_oe,
   output logic link_up,
   output logic wake_req,
   output logic pad_dbg_mode,
   output logic pull_up_req,
   output logic pull_dn_req
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (LR_LEN < 2) begin : g_bad_lr
      $error("LR_LEN must be at least 2");
   end
   if (IDLE_LEN < 2) begin : g_bad_idle
      $error("IDLE_LEN must be at least 2");
   end
   if (PAT_W < 2 || PAT_W > 16) begin : g_bad_pat
      $error("PAT_W must lie in 2..16");
   end

   logic samp;
   logic sbit;
   logic locked;
   logic connected;
   logic conn_evt;
   logic wake_pend_q;

   dlw_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .por_n  (por_n),
      .sck_i  (swclk_pin),
      .dio_i  (swdio_in),
      .samp_o (samp),
      .bit_o  (sbit)
   );

   dlw_seq_detect #(
      .LR_LEN   (LR_LEN),
      .IDLE_LEN (IDLE_LEN),
      .PAT_W    (PAT_W)
   ) u_det (
      .clk       (clk),
      .por_n     (por_n),
      .enable    (~locked),
      .samp      (samp),
      .bit_i     (sbit),
      .connected (connected),
      .conn_evt  (conn_evt)
   );

   dlw_lock u_lock (
      .clk              (clk),
      .por_n            (por_n),
      .rst_pin_held     (rst_pin_held),
      .fw_disable_pulse (fw_disable_pulse),
      .locked           (locked)
   );

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)        wake_pend_q <= 1'b0;
      else if (!shutdown) wake_pend_q <= 1'b0;
      else if (conn_evt)  wake_pend_q <= 1'b1;
   end

   assign link_up      = connected & ~locked;
   assign wake_req     = wake_pend_q & shutdown & ~locked;
   assign swdio_oe     = link_up & dp_drive_req & ~dp_turnaround;
   assign pad_dbg_mode = ~locked;
   assign pull_up_req  = ~locked;
   assign pull_dn_req  = ~locked;
endmodule

// File: rtl/dbg_link_wake_chk.sv
module dbg_link_wake_chk (
   input logic clk,
   input logic por_n,
   input logic dp_turnaround,
   input logic shutdown,
   input logic swdio_oe,
   input logic link_up,
   input logic wake_req,
   input logic pad_dbg_mode,
   input logic pull_up_req
);
   a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!por_n)
      !pad_dbg_mode |=> !pad_dbg_mode);

   a_r3_tat_release: assert property (@(posedge clk) disable iff (!por_n)
      dp_turnaround |-> !swdio_oe);

   a_r3_oe_needs_link: assert property (@(posedge clk) disable iff (!por_n)
      swdio_oe |-> link_up);

   a_r7_locked_quiet: assert property (@(posedge clk) disable iff (!por_n)
      !pull_up_req |-> (!link_up && !wake_req && !swdio_oe));

   a_r4_wake_in_shutdown: assert property (@(posedge clk) disable iff (!por_n)
      wake_req |-> shutdown);

   a_r4_wake_with_link: assert property (@(posedge clk) disable iff (!por_n)
      $rose(wake_req) |-> link_up);
endmodule

bind dbg_link_wake dbg_link_wake_chk u_chk (
   .clk           (clk),
   .por_n         (por_n),
   .dp_turnaround (dp_turnaround),
   .shutdown      (shutdown),
   .swdio_oe      (swdio_oe),
   .link_up       (link_up),
   .wake_req      (wake_req),
   .pad_dbg_mode  (pad_dbg_mode),
   .pull_up_req   (pull_up_req)
);

// File: tb/dbg_link_wake_tb_top.sv
module dbg_link_wake_tb_top;
   localparam int HALF = 5;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic rst_pin_held = 1'b0;
   logic swclk_pin = 1'b0;
   logic swdio_in = 1'b0;
   logic dp_drive_req = 1'b0;
   logic dp_turnaround = 1'b0;
   logic shutdown = 1'b0;
   logic fw_disable_pulse = 1'b0;
   logic swdio_oe, link_up, wake_req, pad_dbg_mode, pull_up_req, pull_dn_req;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   dbg_link_wake dut_i (
      .clk              (clk),
      .por_n            (por_n),
      .rst_pin_held     (rst_pin_held),
      .swclk_pin        (swclk_pin),
      .swdio_in         (swdio_in),
      .dp_drive_req     (dp_drive_req),
      .dp_turnaround    (dp_turnaround),
      .shutdown         (shutdown),
      .fw_disable_pulse (fw_disable_pulse),
      .swdio_oe         (swdio_oe),
      .link_up          (link_up),
      .wake_req         (wake_req),
      .pad_dbg_mode     (pad_dbg_mode),
      .pull_up_req      (pull_up_req),
      .pull_dn_req      (pull_dn_req)
   );

   task automatic check(input string req, input string what, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic sbit(input logic b);
      @(negedge clk) swdio_in = b;
      repeat (HALF) @(negedge clk);
      swclk_pin = 1'b1;
      repeat (HALF) @(negedge clk);
      swclk_pin = 1'b0;
   endtask

   task automatic ones(input int n);
      for (int i = 0; i < n; i++) sbit(1'b1);
   endtask

   task automatic zeros(input int n);
      for (int i = 0; i < n; i++) sbit(1'b0);
   endtask

   task automatic word(input logic [15:0] w);
      for (int i = 0; i < 16; i++) sbit(w[i]);
   endtask

   task automatic settle();
      repeat (8) @(negedge clk);
   endtask

   task automatic flush();
      zeros(20);
      settle();
   endtask

   task automatic connect();
      ones(52); word(16'hE79E); ones(52); zeros(2); settle();
   endtask

   task automatic power_on(input logic hold);
      @(negedge clk);
      por_n = 1'b0; rst_pin_held = hold;
      swclk_pin = 1'b0; swdio_in = 1'b0; shutdown = 1'b0;
      dp_drive_req = 1'b0; dp_turnaround = 1'b0; fw_disable_pulse = 1'b0;
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      repeat (3) @(negedge clk);
      rst_pin_held = 1'b0;
   endtask

   task automatic fw_pulse();
      @(negedge clk) fw_disable_pulse = 1'b1;
      @(negedge clk) fw_disable_pulse = 1'b0;
   endtask

   task automatic t_reset();
      power_on(1'b0);
      check("R1", "pad_dbg_mode", pad_dbg_mode, 1'b1);
      check("R1", "pull_up_req", pull_up_req, 1'b1);
      check("R1", "pull_dn_req", pull_dn_req, 1'b1);
      check("R1", "link_up", link_up, 1'b0);
      check("R1", "wake_req", wake_req, 1'b0);
      check("R1", "swdio_oe", swdio_oe, 1'b0);
   endtask

   task automatic t_connect_idle_boundary();
      flush();
      ones(50); word(16'hE79E); ones(50); zeros(1); settle();
      check("R2", "link after one idle zero", link_up, 1'b0);
      zeros(1); settle();
      check("R2", "link after two idle zeros", link_up, 1'b1);
   endtask

   task automatic t_oe();
      dp_drive_req = 1'b1; dp_turnaround = 1'b0; @(negedge clk);
      check("R3", "oe while driving", swdio_oe, 1'b1);
      dp_turnaround = 1'b1; @(negedge clk);
      check("R3", "oe in turnaround", swdio_oe, 1'b0);
      dp_turnaround = 1'b0; dp_drive_req = 1'b0; @(negedge clk);
      check("R3", "oe without request", swdio_oe, 1'b0);
   endtask

   task automatic t_disconnect();
      ones(52); word(16'hE3BD); settle();
      check("R6", "link after wrong dormant word", link_up, 1'b1);
      ones(52); word(16'hE3BC); settle();
      check("R6", "link after dormant word", link_up, 1'b0);
      dp_drive_req = 1'b1; @(negedge clk);
      check("R3", "oe when unlinked", swdio_oe, 1'b0);
      dp_drive_req = 1'b0;
   endtask

   task automatic t_invalid();
      flush();
      shutdown = 1'b1;
      ones(52); word(16'hE79F); ones(52); zeros(4); settle();
      check("R5", "link after wrong select word", link_up, 1'b0);
      check("R5", "wake after wrong select word", wake_req, 1'b0);
      flush();
      ones(49); word(16'hE79E); ones(52); zeros(4); settle();
      check("R5", "link after 49-one run", link_up, 1'b0);
      check("R5", "wake after 49-one run", wake_req, 1'b0);
      shutdown = 1'b0;
   endtask

   task automatic t_wake();
      flush();
      shutdown = 1'b1; @(negedge clk);
      connect();
      check("R4", "wake after valid handshake", wake_req, 1'b1);
      check("R4", "link with wake", link_up, 1'b1);
      repeat (20) @(negedge clk);
      check("R4", "wake held in shutdown", wake_req, 1'b1);
      shutdown = 1'b0; @(negedge clk);
      check("R4", "wake after shutdown exit", wake_req, 1'b0);
   endtask

   task automatic t_hold_blocks_lock();
      power_on(1'b1);
      fw_pulse(); @(negedge clk);
      check("R8", "pad mode after blocked lock", pad_dbg_mode, 1'b1);
      connect();
      check("R8", "link after blocked lock", link_up, 1'b1);
   endtask

   task automatic t_lock();
      power_on(1'b0);
      connect();
      check("R2", "link before lock", link_up, 1'b1);
      shutdown = 1'b1;
      fw_pulse();
      check("R7", "pad mode after lock", pad_dbg_mode, 1'b0);
      check("R7", "pull up after lock", pull_up_req, 1'b0);
      check("R7", "pull down after lock", pull_dn_req, 1'b0);
      check("R7", "link after lock", link_up, 1'b0);
      flush();
      connect();
      dp_drive_req = 1'b1; @(negedge clk);
      check("R7", "link attempt while locked", link_up, 1'b0);
      check("R7", "wake while locked", wake_req, 1'b0);
      check("R7", "oe while locked", swdio_oe, 1'b0);
      check("R7", "lock still held", pad_dbg_mode, 1'b0);
      dp_drive_req = 1'b0;
      power_on(1'b0);
      check("R7", "pad mode after new power-on", pad_dbg_mode, 1'b1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset();
      t_connect_idle_boundary();
      t_oe();
      t_disconnect();
      t_invalid();
      t_wake();
      t_hold_blocks_lock();
      t_lock();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule